// File: doc/BRIEF.md
# Dynamic Bus Sizing Master Sequencer

This block is a bus master that moves one 32-bit long word per request and lets the addressed slave decide how wide the transfer really is. The sequencer opens every transfer as a long-word cycle. It drives the address, a size code that asks for four bytes, the address strobe and the read/write line. It then waits for the slave's two-bit width acknowledge. A full-width slave completes the whole word in that one cycle. A half-width slave returns or accepts only the upper two bytes. The master then negates the strobe for one clock and runs a second cycle. That cycle asks for two bytes at the address two above the original, so it reaches the remaining half of the word.

For reads, the bytes from each cycle are assembled into a 32-bit result. That result is presented with a one-clock done pulse after the final acknowledge. For writes, the master places the proper halves of the write word onto the data bus in each cycle. A half-width slave always uses the upper sixteen data lines. Requests that arrive while a transfer is running are ignored. The acknowledge pattern for a byte-wide port is outside the block's scope. It is handled as a half-width acknowledge and raises an error status alongside the done pulse.

Top module: `bsz_master`

## Requirements
- R1: While reset is asserted and after it, before any request, the strobe is negated (`bus_as_n`=1), `busy`=0, `done`=0, `bus_rw`=1 (read) and `bus_dout_en`=0.
- R2: A request taken in idle opens a cycle on the next clock with `bus_as_n`=0, `bus_addr` equal to the request address, `bus_size`=2'b00 (four bytes) and `bus_rw`=0 for a write, 1 for a read.
- R3: While the acknowledge reads 2'b11 (idle, both active-low bits high), the strobe stays asserted and the address stays unchanged, for any number of clocks.
- R4: An acknowledge of 2'b00 (full-width port) ends the transfer after that single cycle. For a read, `rdata` equals the full 32-bit `bus_din` sampled with that acknowledge.
- R5: An acknowledge of 2'b01 (bit 1 asserted low, bit 0 high: half-width port) on the first cycle is followed by one clock with the strobe negated. A second cycle then opens with `bus_size`=2'b10 (two bytes) and `bus_addr` equal to the original address plus 2.
- R6: For a half-width read, `rdata[31:16]` holds `bus_din[31:16]` from the first cycle and `rdata[15:0]` holds `bus_din[31:16]` from the second cycle. The lower data lines are ignored.
- R7: For a write, the first cycle drives the whole write word on `bus_dout`. A second cycle drives write bits 15:0 on `bus_dout[31:16]`, duplicated on `bus_dout[15:0]`. `bus_dout_en` is 1 only while the strobe is asserted in a write, with `bus_rw`=0.
- R8: `done` is a single-clock pulse in the clock after the final acknowledge. No pulse follows a first-cycle half-width acknowledge.
- R9: A request presented while a transfer is in progress is ignored. The address and cycle sequence are unchanged, and no new cycle starts after the transfer ends.
- R10: An acknowledge of 2'b10 (byte-port pattern) is treated as half-width, and `size_err` is 1 when the transfer's `done` pulses. The next request clears `size_err`.
- R11: After every non-idle acknowledge the strobe is negated in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Transfer request, taken only when idle |
| req_addr | input | ADDR_W | Long-word start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write word |
| bus_addr | output | ADDR_W | Bus address of the current cycle |
| bus_size | output | 2 | Size code: 2'b00 four bytes, 2'b10 two bytes |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | DATA_W | Write data lanes |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data lanes |
| bus_ack_n | input | 2 | Width acknowledge, active low; 2'b11 means no acknowledge yet |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Assembled read word, valid with `done` |
| size_err | output | 1 | Byte-port acknowledge seen in the last transfer |

## Verification
The bench drives half-width reads with distinct values on the lower data lanes. A design that merged the lower lanes, or swapped the halves, returns a wrong word. Wait states of varying length check that the address holds steady. A sequencer that advanced early would show the incremented address too soon, or drop the strobe. Half-width writes check the lane duplication, and checks after a first-cycle half acknowledge catch a premature `done`. A request held high through a whole transfer exposes a master that re-arms while busy, or starts a spurious cycle afterwards. A byte-pattern acknowledge followed by a clean transfer checks that the error flag rises and then clears.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC  = 2'd1,
    ST_GAP  = 2'd2
  } bsz_state_e;

  // width acknowledge codes, active low {bit1, bit0}
  localparam logic [1:0] ACK_NONE = 2'b11;
  localparam logic [1:0] ACK_WIDE = 2'b00;
  localparam logic [1:0] ACK_HALF = 2'b01;
  localparam logic [1:0] ACK_BYTE = 2'b10;

  // transfer size codes
  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] ack_n,
  output logic       accept,
  output logic       ack_seen,
  output logic       last,
  output logic       second,
  output logic       strobe_on,
  output logic       busy,
  output logic       done,
  output logic       err
);

  bsz_state_e st_q, st_d;
  logic       second_q, second_d;
  logic       err_q, err_d;
  logic       done_q, done_d;

  always_comb begin
    accept   = (st_q == ST_IDLE) && req_valid;
    ack_seen = (st_q == ST_CYC) && (ack_n != ACK_NONE);
    last     = ack_seen && (second_q || (ack_n == ACK_WIDE));

    st_d     = st_q;
    second_d = second_q;
    err_d    = err_q;
    done_d   = last;

    case (st_q)
      ST_IDLE: if (accept) st_d = ST_CYC;
      ST_CYC:  if (ack_seen) st_d = last ? ST_IDLE : ST_GAP;
      ST_GAP:  st_d = ST_CYC;
      default: st_d = ST_IDLE;
    endcase

    if (accept) begin
      second_d = 1'b0;
      err_d    = 1'b0;
    end else begin
      if (ack_seen && !last)         second_d = 1'b1;
      if (ack_seen && ack_n == ACK_BYTE) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      second_q <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      second_q <= second_d;
      err_q    <= err_d;
      done_q   <= done_d;
    end
  end

  assign second    = second_q;
  assign strobe_on = (st_q == ST_CYC);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ack_seen,
  input  logic              last,
  input  logic              second,
  input  logic              strobe_on,
  input  logic              busy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  output logic              bus_rw,
  output logic [DATA_W-1:0] rdata
);

  localparam int HALF       = DATA_W / 2;
  localparam int HALF_BYTES = HALF / 8;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [HALF-1:0]   upper_in;

  assign upper_in = bus_din[DATA_W-1:HALF];

  always_comb begin
    addr_d  = addr_q;
    wr_d    = wr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (accept) begin
      addr_d  = req_addr;
      wr_d    = req_write;
      wdata_d = req_wdata;
    end else if (ack_seen) begin
      if (!last) begin
        addr_d                    = addr_q + ADDR_W'(HALF_BYTES);
        rdata_d[DATA_W-1:HALF]    = upper_in;
      end else if (second) begin
        rdata_d[HALF-1:0]         = upper_in;
      end else begin
        rdata_d                   = bus_din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  // second half of a write goes out on the upper lanes, mirrored below
  assign bus_dout    = second ? {2{wdata_q[HALF-1:0]}} : wdata_q;
  assign bus_dout_en = strobe_on && wr_q;
  assign bus_rw      = !(wr_q && busy);
  assign bus_addr    = addr_q;
  assign rdata       = rdata_q;

endmodule

// File: rtl/bsz_master.sv
module bsz_master
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_as_n,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [1:0]        bus_ack_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              size_err
);

  logic core_rst_n;
  logic accept, ack_seen, last, second, strobe_on;

  // reset: asserted asynchronously, released through a short flop chain
  generate
    if (SYNC_N > 1) begin : g_rsync
      logic [SYNC_N-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
      end
      assign core_rst_n = rs_q[SYNC_N-1];
    end else begin : g_rsync1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign core_rst_n = rs_q;
    end
  endgenerate

  bsz_seq u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .req_valid (req_valid),
    .ack_n     (bus_ack_n),
    .accept    (accept),
    .ack_seen  (ack_seen),
    .last      (last),
    .second    (second),
    .strobe_on (strobe_on),
    .busy      (busy),
    .done      (done),
    .err       (size_err)
  );

  bsz_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .accept      (accept),
    .ack_seen    (ack_seen),
    .last        (last),
    .second      (second),
    .strobe_on   (strobe_on),
    .busy        (busy),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .bus_din     (bus_din),
    .bus_addr    (bus_addr),
    .bus_dout    (bus_dout),
    .bus_dout_en (bus_dout_en),
    .bus_rw      (bus_rw),
    .rdata       (rdata)
  );

  assign bus_as_n = !strobe_on;
  assign bus_size = second ? SZ_WORD : SZ_LONG;

endmodule

// File: rtl/bsz_master_chk.sv
module bsz_master_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_as_n,
  input logic [1:0]        bus_ack_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_rw,
  input logic              bus_dout_en,
  input logic              done
);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && bus_ack_n == 2'b11) |=> (!bus_as_n && $stable(bus_addr)));

  // R11
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && bus_ack_n != 2'b11) |=> bus_as_n);

  // R4
  wide_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && bus_size == 2'b00 && bus_ack_n == 2'b00) |=> done);

  // R5
  second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && bus_size == 2'b00 && (bus_ack_n == 2'b01 || bus_ack_n == 2'b10))
    |=> ##1 (!bus_as_n && bus_size == 2'b10 &&
             bus_addr == $past(bus_addr, 2) + ADDR_W'(2)));

  // R8
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && bus_size == 2'b00 && (bus_ack_n == 2'b01 || bus_ack_n == 2'b10))
    |=> !done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  dout_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> (!bus_as_n && !bus_rw));

endmodule

bind bsz_master bsz_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_as_n    (bus_as_n),
  .bus_ack_n   (bus_ack_n),
  .bus_addr    (bus_addr),
  .bus_size    (bus_size),
  .bus_rw      (bus_rw),
  .bus_dout_en (bus_dout_en),
  .done        (done)
);

// File: tb/bsz_master_bench.sv
module bsz_master_bench;

  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] bus_din = '0;
  logic [1:0]    bus_ack_n = 2'b11;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          bus_as_n, bus_rw, bus_dout_en, busy, done, size_err;
  logic [DW-1:0] bus_dout, rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bsz_master u_bsz_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_as_n(bus_as_n), .bus_rw(bus_rw),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_ack_n(bus_ack_n), .busy(busy), .done(done), .rdata(rdata),
    .size_err(size_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one complete transfer with the bench acting as slave
  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] wd,
                      input logic [1:0] ack1, input logic [1:0] ack2, input int waits,
                      input logic spam, input logic [DW-1:0] d1, input logic [DW-1:0] d2);
    logic          narrow;
    logic          exp_err;
    logic [DW-1:0] exp_rd;
    narrow  = (ack1 != 2'b00);
    exp_err = (ack1 == 2'b10) || (narrow && ack2 == 2'b10);
    exp_rd  = narrow ? {d1[31:16], d2[31:16]} : d1;

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd;
    @(negedge clk);
    if (spam) begin
      req_addr = a ^ 24'h800000; req_write = !w; req_wdata = ~wd;
    end else req_valid = 1'b0;
    chk("R2 strobe", {63'd0, bus_as_n}, 64'd0);
    chk("R2 addr", {40'd0, bus_addr}, {40'd0, a});
    chk("R2 size", {62'd0, bus_size}, 64'd0);
    chk("R2 rw", {63'd0, bus_rw}, {63'd0, !w});
    if (w) begin
      chk("R7 dout first", {32'd0, bus_dout}, {32'd0, wd});
      chk("R7 dout_en", {63'd0, bus_dout_en}, 64'd1);
    end
    for (int i = 0; i < waits; i++) begin
      bus_ack_n = 2'b11;
      @(negedge clk);
      chk("R3 strobe held", {63'd0, bus_as_n}, 64'd0);
      chk("R3 addr held", {40'd0, bus_addr}, {40'd0, a});
    end
    bus_ack_n = ack1; bus_din = d1;
    @(negedge clk);
    bus_ack_n = 2'b11; bus_din = 32'hDEAD_BEEF;
    chk("R11 gap", {63'd0, bus_as_n}, 64'd1);
    if (narrow) begin
      chk("R8 no early done", {63'd0, done}, 64'd0);
      chk("R7 dout_en off", {63'd0, bus_dout_en}, 64'd0);
      @(negedge clk);
      chk("R5 strobe", {63'd0, bus_as_n}, 64'd0);
      chk("R5 size", {62'd0, bus_size}, 64'd2);
      chk("R5 addr", {40'd0, bus_addr}, {40'd0, a + 24'd2});
      if (spam) chk("R9 addr", {40'd0, bus_addr}, {40'd0, a + 24'd2});
      if (w) begin
        chk("R7 dout second", {32'd0, bus_dout}, {32'd0, wd[15:0], wd[15:0]});
        chk("R7 rw", {63'd0, bus_rw}, 64'd0);
      end
      for (int i = 0; i < waits; i++) begin
        bus_ack_n = 2'b11;
        @(negedge clk);
        chk("R3 strobe held", {63'd0, bus_as_n}, 64'd0);
        chk("R3 addr held", {40'd0, bus_addr}, {40'd0, a + 24'd2});
      end
      bus_ack_n = ack2; bus_din = d2;
      @(negedge clk);
      bus_ack_n = 2'b11; bus_din = 32'h0BAD_F00D;
      chk("R11 gap", {63'd0, bus_as_n}, 64'd1);
    end
    req_valid = 1'b0;
    chk("R8 done", {63'd0, done}, 64'd1);
    if (!w) chk(narrow ? "R6 read assembly" : "R4 wide read", {32'd0, rdata}, {32'd0, exp_rd});
    chk("R10 size_err", {63'd0, size_err}, {63'd0, exp_err});
    @(negedge clk);
    chk("R8 done single", {63'd0, done}, 64'd0);
    chk(spam ? "R9 no restart" : "R11 idle", {63'd0, bus_as_n}, 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 strobe", {63'd0, bus_as_n}, 64'd1);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 rw", {63'd0, bus_rw}, 64'd1);
    chk("R1 dout_en", {63'd0, bus_dout_en}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after", {63'd0, bus_as_n}, 64'd1);
    chk("R1 busy after", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_wide_read();
    xfer(24'h001000, 1'b0, '0, 2'b00, 2'b11, 0, 1'b0, 32'h1122_3344, 32'h0);
    xfer(24'h00ABC4, 1'b0, '0, 2'b00, 2'b11, 3, 1'b0, 32'hCAFE_0001, 32'h0);
  endtask

  task automatic t_half_read();
    xfer(24'h002000, 1'b0, '0, 2'b01, 2'b01, 0, 1'b0, 32'hA1B2_FFFF, 32'hC3D4_0000);
    xfer(24'hFFFFFC, 1'b0, '0, 2'b01, 2'b01, 2, 1'b0, 32'h5566_1234, 32'h7788_9ABC);
  endtask

  task automatic t_writes();
    xfer(24'h003000, 1'b1, 32'h0102_0304, 2'b00, 2'b11, 1, 1'b0, '0, '0);
    xfer(24'h003100, 1'b1, 32'hF0E1_D2C3, 2'b01, 2'b01, 1, 1'b0, '0, '0);
  endtask

  task automatic t_busy_ignore();
    xfer(24'h004000, 1'b0, '0, 2'b01, 2'b01, 2, 1'b1, 32'h9999_0000, 32'h8888_1111);
  endtask

  task automatic t_byte_ack();
    xfer(24'h005000, 1'b0, '0, 2'b10, 2'b01, 0, 1'b0, 32'hBEEF_0000, 32'hFACE_0000);
    xfer(24'h005100, 1'b0, '0, 2'b00, 2'b11, 0, 1'b0, 32'h1357_9BDF, 32'h0);
    xfer(24'h005200, 1'b1, 32'h2468_ACE0, 2'b01, 2'b10, 0, 1'b0, '0, '0);
  endtask

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wide_read();
    t_half_read();
    t_writes();
    t_busy_ignore();
    t_byte_ack();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule